// File: doc/BRIEF.md
# Debug Observation Pin Multiplexer

This block sits between the core's general-purpose port logic and the pad ring. In normal operation it passes the port data register bits and their direction bits to the pins unchanged, and it passes the expansion chip-select decode straight through. When the debug-enable control bit is set, the same pins also show what the core is doing. The active-low expansion chip-select also goes low for every internal I/O access, so a logic analyser on the expansion bus sees all internal traffic. Three fixed port pins carry the CPU clock and the two active-low interrupt request lines in place of their data bits. The clock marks where each access begins and ends.

A debug signal reaches a pin only if software has made that pin an output. The output enables always follow the direction bits. Port pins other than the three tap positions are never changed by debug mode. The pin values, output enables and chip-select pass through one output register stage clocked by the CPU clock. The clock tap is the one exception: it forwards the clock itself through a mux whose select is registered.

Top module: `dbgmux_top`

## Requirements
- R1: While reset is asserted, every pin value is 0, every output enable is 0 and the chip-select output is high.
- R2: With debug disabled, the pin values equal the port data bits and the chip-select output equals the normal chip-select.
- R3: With debug enabled, the chip-select output is low when the internal I/O strobe (active low) is low, even if the normal chip-select is high. It is high only when both are high.
- R4: With debug enabled and the strobe high, the chip-select output still follows the normal chip-select, so its standard address range keeps working.
- R5: With debug enabled and direction bit 0 set, pin 0 carries the CPU clock: high during the clock's high phase, low during its low phase.
- R6: With debug enabled and direction bit 1 set, pin 1 carries the normal interrupt request line (active low).
- R7: With debug enabled and direction bit 2 set, pin 2 carries the fast interrupt request line (active low).
- R8: On a tap pin whose direction bit is 0 (input), debug mode has no effect: the output enable is 0 and the pin value is the port data bit.
- R9: Pins other than 0, 1 and 2 always carry their port data bit, whatever the debug state.
- R10: Each output enable equals the corresponding direction bit (1 = output), whatever the debug state.
- R11: With debug disabled, the internal I/O strobe has no effect on the chip-select output.
- R12: Pin values, output enables and chip-select reflect the inputs sampled at the previous rising clock edge. A change made between edges does not show before the next rising edge.

Ports are listed for the default `PORT_W` = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; clocks the output stage and is forwarded on pin 0 |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_en | input | 1 | Debug-mode enable control bit |
| port_dir | input | 8 | Direction bits, 1 = output |
| port_dat | input | 8 | Port data register bits |
| cs_n_norm | input | 1 | Normal expansion chip-select decode, active low |
| io_strb_n | input | 1 | Internal I/O access strobe, active low |
| irq_n | input | 1 | Normal interrupt request, active low |
| fiq_n | input | 1 | Fast interrupt request, active low |
| port_o | output | 8 | Pin output values |
| port_oe | output | 8 | Pin output enables |
| cs_n_o | output | 1 | Expansion chip-select to the pad, active low |

## Verification
The registered tap select for pin 0 controls whether the pin shows the clock. If that bit is wrong, pin 0 is wrong in the very next clock phase after the edge that loaded it: the pin either toggles when it should hold data, or holds data when it should toggle. A wrong bit in the registered pin values, enables or chip-select appears at the ports right after the following rising edge and stays until the next edge reloads it. So every stimulus is checked twice: just before the edge, where the previous result must still hold, and just after it, where the new result must appear. Several vectors swap data and interrupt levels between neighbouring pins, so that a tap routed to the wrong pin position shows up.

// File: rtl/dbgmux_pkg.sv
package dbgmux_pkg;

   typedef enum logic [1:0] {
      TAP_NONE = 2'd0,
      TAP_CLK  = 2'd1,
      TAP_IRQ  = 2'd2,
      TAP_FIQ  = 2'd3
   } tap_e;

   function automatic tap_e tap_of(input int idx, input int clk_b,
                                   input int irq_b, input int fiq_b);
      if (idx == clk_b)      return TAP_CLK;
      else if (idx == irq_b) return TAP_IRQ;
      else if (idx == fiq_b) return TAP_FIQ;
      else                   return TAP_NONE;
   endfunction

endpackage

// File: rtl/dbgmux_cs_merge.sv
module dbgmux_cs_merge (
   input  logic dbg_en,
   input  logic cs_n_norm,
   input  logic io_strb_n,
   output logic cs_n_d
);
   logic strb_gated_n;

   always_comb begin
      strb_gated_n = dbg_en ? io_strb_n : 1'b1;
      cs_n_d       = cs_n_norm & strb_gated_n;
   end
endmodule

// File: rtl/dbgmux_pin_sel.sv
module dbgmux_pin_sel #(
   parameter int PORT_W  = 8,
   parameter int CLK_BIT = 0,
   parameter int IRQ_BIT = 1,
   parameter int FIQ_BIT = 2
) (
   input  logic              dbg_en,
   input  logic [PORT_W-1:0] port_dir,
   input  logic [PORT_W-1:0] port_dat,
   input  logic              irq_n,
   input  logic              fiq_n,
   output logic [PORT_W-1:0] val_d,
   output logic              fwd_d
);
   import dbgmux_pkg::*;

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      localparam tap_e TAP = tap_of(i, CLK_BIT, IRQ_BIT, FIQ_BIT);
      logic take;
      assign take = dbg_en & port_dir[i];
      if (TAP == TAP_IRQ) begin : g_irq
         assign val_d[i] = take ? irq_n : port_dat[i];
      end else if (TAP == TAP_FIQ) begin : g_fiq
         assign val_d[i] = take ? fiq_n : port_dat[i];
      end else if (TAP == TAP_CLK) begin : g_clk
         assign val_d[i] = port_dat[i];
         assign fwd_d    = take;
      end else begin : g_plain
         assign val_d[i] = port_dat[i];
      end
   end
endmodule

// File: rtl/dbgmux_out_stage.sv
module dbgmux_out_stage #(
   parameter int PORT_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] val_d,
   input  logic [PORT_W-1:0] oe_d,
   input  logic              cs_n_d,
   input  logic              fwd_d,
   output logic [PORT_W-1:0] val_q,
   output logic [PORT_W-1:0] oe_q,
   output logic              cs_n_q,
   output logic              fwd_q
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            oe_q   <= '0;
            cs_n_q <= 1'b1;
            fwd_q  <= 1'b0;
         end else begin
            val_q  <= val_d;
            oe_q   <= oe_d;
            cs_n_q <= cs_n_d;
            fwd_q  <= fwd_d;
         end
      end
   end else begin : g_thru
      assign val_q  = val_d;
      assign oe_q   = oe_d;
      assign cs_n_q = cs_n_d;
      assign fwd_q  = fwd_d;
   end
endmodule

// File: rtl/dbgmux_top.sv
module dbgmux_top #(
   parameter int PORT_W  = 8,
   parameter int CLK_BIT = 0,
   parameter int IRQ_BIT = 1,
   parameter int FIQ_BIT = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_en,
   input  logic [PORT_W-1:0] port_dir,
   input  logic [PORT_W-1:0] port_dat,
   input  logic              cs_n_norm,
   input  logic              io_strb_n,
   input  logic              irq_n,
   input  logic              fiq_n,
   output logic [PORT_W-1:0] port_o,
   output logic [PORT_W-1:0] port_oe,
   output logic              cs_n_o
);
   localparam int MIN_W = 3;

   if (PORT_W < MIN_W) begin : g_bad_w
      $error("dbgmux_top: PORT_W must be at least 3");
   end
   if (CLK_BIT >= PORT_W || IRQ_BIT >= PORT_W || FIQ_BIT >= PORT_W) begin : g_bad_pos
      $error("dbgmux_top: tap position outside the port");
   end
   if (CLK_BIT == IRQ_BIT || CLK_BIT == FIQ_BIT || IRQ_BIT == FIQ_BIT) begin : g_dup_pos
      $error("dbgmux_top: tap positions must differ");
   end

   logic [PORT_W-1:0] val_d, val_q, oe_q;
   logic              cs_n_d, cs_n_q, fwd_d, fwd_q;

   dbgmux_cs_merge u_cs (
      .dbg_en    (dbg_en),
      .cs_n_norm (cs_n_norm),
      .io_strb_n (io_strb_n),
      .cs_n_d    (cs_n_d)
   );

   dbgmux_pin_sel #(
      .PORT_W  (PORT_W),
      .CLK_BIT (CLK_BIT),
      .IRQ_BIT (IRQ_BIT),
      .FIQ_BIT (FIQ_BIT)
   ) u_sel (
      .dbg_en   (dbg_en),
      .port_dir (port_dir),
      .port_dat (port_dat),
      .irq_n    (irq_n),
      .fiq_n    (fiq_n),
      .val_d    (val_d),
      .fwd_d    (fwd_d)
   );

   dbgmux_out_stage #(
      .PORT_W  (PORT_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .val_d  (val_d),
      .oe_d   (port_dir),
      .cs_n_d (cs_n_d),
      .fwd_d  (fwd_d),
      .val_q  (val_q),
      .oe_q   (oe_q),
      .cs_n_q (cs_n_q),
      .fwd_q  (fwd_q)
   );

   // the clock tap bypasses the register: the registered select only chooses the source
   always_comb begin
      port_o          = val_q;
      port_o[CLK_BIT] = fwd_q ? clk : val_q[CLK_BIT];
   end
   assign port_oe = oe_q;
   assign cs_n_o  = cs_n_q;
endmodule

// File: rtl/dbgmux_chk.sv
module dbgmux_chk #(
   parameter int PORT_W  = 8,
   parameter int CLK_BIT = 0,
   parameter int IRQ_BIT = 1,
   parameter int FIQ_BIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_en,
   input logic [PORT_W-1:0] port_dir,
   input logic [PORT_W-1:0] port_dat,
   input logic              cs_n_norm,
   input logic              io_strb_n,
   input logic              irq_n,
   input logic              fiq_n,
   input logic [PORT_W-1:0] port_o,
   input logic [PORT_W-1:0] port_oe,
   input logic              cs_n_o
);
   localparam logic [PORT_W-1:0] TAP_MASK =
      (PORT_W'(1) << CLK_BIT) | (PORT_W'(1) << IRQ_BIT) | (PORT_W'(1) << FIQ_BIT);

   p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(dbg_en) |-> port_o == $past(port_dat));

   p_strobe_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(dbg_en) && !$past(io_strb_n) |-> !cs_n_o);

   p_norm_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(cs_n_norm) |-> !cs_n_o);

   // sampled just before the rising edge, the forwarded clock is in its low phase
   p_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(dbg_en) && $past(port_dir[CLK_BIT]) |-> !port_o[CLK_BIT]);

   p_irq_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(dbg_en) && $past(port_dir[IRQ_BIT])
      |-> port_o[IRQ_BIT] == $past(irq_n));

   p_fiq_tap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(dbg_en) && $past(port_dir[FIQ_BIT])
      |-> port_o[FIQ_BIT] == $past(fiq_n));

   p_in_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(port_dir[IRQ_BIT])
      |-> port_o[IRQ_BIT] == $past(port_dat[IRQ_BIT]));

   p_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (port_o & ~TAP_MASK) == ($past(port_dat) & ~TAP_MASK));

   p_oe_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> port_oe == $past(port_dir));

   p_strobe_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(dbg_en) |-> cs_n_o == $past(cs_n_norm));
endmodule

bind dbgmux_top dbgmux_chk #(
   .PORT_W  (PORT_W),
   .CLK_BIT (CLK_BIT),
   .IRQ_BIT (IRQ_BIT),
   .FIQ_BIT (FIQ_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dbg_en    (dbg_en),
   .port_dir  (port_dir),
   .port_dat  (port_dat),
   .cs_n_norm (cs_n_norm),
   .io_strb_n (io_strb_n),
   .irq_n     (irq_n),
   .fiq_n     (fiq_n),
   .port_o    (port_o),
   .port_oe   (port_oe),
   .cs_n_o    (cs_n_o)
);

// File: tb/sim_dbgmux_top.sv
`timescale 1ns/1ps
module sim_dbgmux_top;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] val;
      logic [W-1:0] oe;
      logic         cs;
      logic         fwd;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         dbg_en;
   logic [W-1:0] port_dir, port_dat;
   logic         cs_n_norm, io_strb_n, irq_n, fiq_n;
   logic [W-1:0] port_o, port_oe;
   logic         cs_n_o;

   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;
   exp_t q[$];
   exp_t prev;

   always #2 clk = ~clk;

   dbgmux_top #(.PORT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .port_dir(port_dir),
      .port_dat(port_dat), .cs_n_norm(cs_n_norm), .io_strb_n(io_strb_n),
      .irq_n(irq_n), .fiq_n(fiq_n), .port_o(port_o), .port_oe(port_oe),
      .cs_n_o(cs_n_o)
   );

   task automatic check(input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, expv);
      end
   endtask

   // expected result with the clock in its high phase
   function automatic exp_t model(input string tag);
      exp_t e;
      logic take0, take1, take2;
      take0 = dbg_en & port_dir[0];
      take1 = dbg_en & port_dir[1];
      take2 = dbg_en & port_dir[2];
      e.val = port_dat;
      if (take0) e.val[0] = 1'b1;
      if (take1) e.val[1] = irq_n;
      if (take2) e.val[2] = fiq_n;
      e.oe  = port_dir;
      e.cs  = cs_n_norm & (dbg_en ? io_strb_n : 1'b1);
      e.fwd = take0;
      e.tag = tag;
      return e;
   endfunction

   task automatic apply(input string tag, input logic d, input logic [W-1:0] dir,
                        input logic [W-1:0] dat, input logic cs, input logic strb,
                        input logic irq, input logic fiq);
      logic [W-1:0] hold_val;
      @(negedge clk);
      dbg_en = d; port_dir = dir; port_dat = dat;
      cs_n_norm = cs; io_strb_n = strb; irq_n = irq; fiq_n = fiq;
      #1;
      // R12: nothing changes before the next rising edge; R5 low phase on pin 0
      hold_val = prev.val;
      if (prev.fwd) hold_val[0] = 1'b0;
      check({"R12/R5 hold val ", tag}, port_o, hold_val);
      check({"R12 hold oe ", tag}, port_oe, prev.oe);
      check({"R12 hold cs ", tag}, W'(cs_n_o), W'(prev.cs));
      prev = model(tag);
      q.push_back(prev);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({"val ", e.tag}, port_o, e.val);
            check({"oe ", e.tag}, port_oe, e.oe);
            check({"cs ", e.tag}, W'(cs_n_o), W'(e.cs));
         end
      end
   end

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      rst_n = 1'b0;
      dbg_en = 1'b1; port_dir = '1; port_dat = 8'hFF;
      cs_n_norm = 1'b0; io_strb_n = 1'b0; irq_n = 1'b0; fiq_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset val", port_o, '0);
      check("R1 reset oe", port_oe, '0);
      check("R1 reset cs", W'(cs_n_o), W'(1'b1));
      @(negedge clk);
      dbg_en = 1'b0; port_dir = '0; port_dat = '0;
      cs_n_norm = 1'b1; io_strb_n = 1'b1; irq_n = 1'b1; fiq_n = 1'b1;
      rst_n = 1'b1;
      prev = model("init");

      apply("R2 R11 off strobe low",   1'b0, 8'hFF, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
      apply("R2 off cs low",           1'b0, 8'hFF, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1);
      apply("R3 R5 R6 R7 strobe",      1'b1, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
      apply("R4 R9 norm range",        1'b1, 8'hFF, 8'hF8, 1'b0, 1'b1, 1'b1, 1'b0);
      apply("R3 both high",            1'b1, 8'hFF, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
      apply("R8 R10 taps input",       1'b1, 8'hF8, 8'h07, 1'b1, 1'b1, 1'b0, 1'b0);
      apply("R6 R8 only irq out",      1'b1, 8'h02, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
      apply("R7 R8 only fiq out",      1'b1, 8'h04, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
      apply("R5 only clk out",         1'b1, 8'h01, 8'hC2, 1'b1, 1'b1, 1'b1, 1'b1);
      apply("R9 R2 back to off",       1'b0, 8'h0F, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0);
      apply("R11 off both low",        1'b0, 8'hAA, 8'h81, 1'b0, 1'b0, 1'b1, 1'b0);
      apply("R3 R10 dbg mixed dir",    1'b1, 8'h55, 8'h99, 1'b1, 1'b0, 1'b1, 1'b0);
      apply("R4 R9 dbg strobe high",   1'b1, 8'hE6, 8'h6E, 1'b0, 1'b1, 1'b0, 1'b1);
      repeat (3) @(posedge clk);
      #1;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule